// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block tests a word-addressed synchronous RAM that returns read data one clock after a read strobe. When started, it drives the RAM address, write data, write enable and read strobe itself. It then runs one of three algorithms. The first is a march test. The second is an address-complement test, which pairs every address with its bitwise inverse. The third is a two-dimensional checkerboard test. Each algorithm runs twice: once with its base data and once with that data inverted.

Each read is checked against the value the sequence put there. The first mismatch is captured: its address, the expected word, the word actually read, and the algorithm number. A stop-on-fail input chooses whether the run ends at that mismatch or continues to the end. When the run finishes, `done` stays high until the next accepted start. `pass` reports whether no mismatch occurred.

Top module: `ram_bist`

## Requirements
- R1: While reset is applied, `busy`, `done`, `pass`, `mem_we` and `mem_re` are all low.
- R2: A start pulse has no effect when `algo_sel` is 3. It is also ignored while `busy` is high. In both cases the bus activity and the run length stay those of the idle state or of the run already in progress.
- R3: With `algo_sel` = 0 (march), the block first writes zero to every address in ascending order. Then, in ascending order, it does the following at each address: read (expect zero), write all-ones, read (expect all-ones). Then, in descending order, it does the following at each address: read (expect all-ones), write zero, read (expect zero).
- R4: The march sequence of R3 then runs a second time with every data word inverted.
- R5: With `algo_sel` = 1, the block writes the checkerboard of R6 in ascending order. Then, for k = 0, 1, … up to the top address, it reads address k and then address ~k. This whole test then repeats with the inverted checkerboard.
- R6: With `algo_sel` = 2, the block writes the checkerboard in ascending order, reads every address back in ascending order, and then repeats both steps with inverted data. The checkerboard word at address a is 0xAA (bit i = i mod 2) when a[0] XOR a[COL_W] is 0, and 0x55 otherwise.
- R7: Read data is compared in the clock cycle after the cycle in which `mem_re` is high. This matches a RAM with one cycle of read latency.
- R8: The first mismatch of a run latches the failing address, expected word, read word and algorithm number. Later mismatches in the same run do not change them. A new accepted start clears them.
- R9: With `stop_on_fail` high, a mismatch ends the run at the clock edge that ends its compare cycle. `busy` is low in the next cycle.
- R10: A run keeps `busy` high for one cycle per RAM operation plus one trailing compare cycle. That is 225 cycles for march, 97 for address-complement and 65 for checkerboard with 16 words. Then `done` goes high and stays high until the next accepted start. `pass` is high only when `done` is high and no mismatch occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled on a rising edge |
| algo_sel | input | 2 | 0 march, 1 address-complement, 2 checkerboard, 3 invalid |
| stop_on_fail | input | 1 | End the run at the first mismatch |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read strobe |
| mem_rdata | input | DW | RAM read data, valid one cycle after `mem_re` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Finished run saw no mismatch |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | DW | Expected word at the first mismatch |
| fail_act | output | DW | Word read at the first mismatch |
| fail_algo | output | 2 | Algorithm running at the first mismatch |

## Verification
The RAM bus outputs come straight from the sequencer registers. Each operation is therefore visible in the cycle after the edge that advances the sequencer, starting one cycle after the edge that accepts the start. The bench samples those outputs on the falling edge and pops one expected operation per active cycle.

A read's compare, and any failure capture, take effect at the edge that closes the cycle after the read. The bench reads the failure fields only once `busy` has dropped, which is one further cycle after the last compare. Run length is counted as falling edges with `busy` high. This gives the exact cycle of an early stop: the failing read's operation index plus one.

// File: rtl/ram_bist_pkg.sv
package ram_bist_pkg;

  typedef enum logic [1:0] {
    ALG_MARCH = 2'd0,
    ALG_ACOMP = 2'd1,
    ALG_CHKR  = 2'd2,
    ALG_NONE  = 2'd3
  } alg_e;

  // One RAM operation inside a per-address step.
  typedef struct packed {
    logic wr;        // 1 = write, 0 = read
    logic cpl_addr;  // use the inverted address
    logic inv;       // invert the base data
  } op_t;

  // One pass over the address space.
  typedef struct packed {
    logic [1:0]   last_op;  // index of the final op per address
    logic         down;     // descending address order
    logic         pol;      // whole-pass data inversion
    logic         last_ph;  // final pass of the algorithm
    op_t [2:0]    ops;
  } phase_t;

  function automatic op_t mk_op(input logic wr, input logic cpl, input logic inv);
    op_t o;
    o.wr = wr;
    o.cpl_addr = cpl;
    o.inv = inv;
    return o;
  endfunction

  // Pass table, computed from algorithm and pass index.
  function automatic phase_t phase_decode(input alg_e alg, input logic [2:0] ph);
    phase_t p;
    logic [1:0] j;
    p = '0;
    case (alg)
      ALG_MARCH: begin
        p.pol     = (ph >= 3'd3);
        j         = p.pol ? 2'(ph - 3'd3) : ph[1:0];
        p.last_ph = (ph == 3'd5);
        case (j)
          2'd0: p.ops[0] = mk_op(1'b1, 1'b0, 1'b0);
          2'd1: begin
            p.last_op = 2'd2;
            p.ops[0] = mk_op(1'b0, 1'b0, 1'b0);
            p.ops[1] = mk_op(1'b1, 1'b0, 1'b1);
            p.ops[2] = mk_op(1'b0, 1'b0, 1'b1);
          end
          default: begin
            p.last_op = 2'd2;
            p.down = 1'b1;
            p.ops[0] = mk_op(1'b0, 1'b0, 1'b1);
            p.ops[1] = mk_op(1'b1, 1'b0, 1'b0);
            p.ops[2] = mk_op(1'b0, 1'b0, 1'b0);
          end
        endcase
      end
      ALG_ACOMP: begin
        p.pol     = ph[1];
        p.last_ph = (ph == 3'd3);
        if (!ph[0]) p.ops[0] = mk_op(1'b1, 1'b0, 1'b0);
        else begin
          p.last_op = 2'd1;
          p.ops[0] = mk_op(1'b0, 1'b0, 1'b0);
          p.ops[1] = mk_op(1'b0, 1'b1, 1'b0);
        end
      end
      ALG_CHKR: begin
        p.pol     = ph[1];
        p.last_ph = (ph == 3'd3);
        p.ops[0]  = mk_op(!ph[0], 1'b0, 1'b0);
      end
      default: p.last_ph = 1'b1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ram_bist_seq.sv
module ram_bist_seq
  import ram_bist_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int COL_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          halt,
  input  alg_e          alg_in,
  output alg_e          alg_cur,
  output logic          running,
  output logic          seq_last,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] op_data,
  output logic          mem_we,
  output logic          mem_re
);

  localparam logic [AW-1:0] ADDR_TOP = '1;

  // Two-dimensional checkerboard: row bit 0 against column bit 0.
  function automatic logic [DW-1:0] cb_word(input logic [AW-1:0] a);
    logic [DW-1:0] alt;
    for (int i = 0; i < DW; i++) alt[i] = (i % 2) == 1;
    return (a[0] ^ a[COL_W]) ? ~alt : alt;
  endfunction

  logic [2:0]    ph;
  logic [AW-1:0] k;
  logic [1:0]    opi;
  alg_e          alg_q;

  phase_t        cur;
  op_t           op;
  logic [AW-1:0] base;
  logic          op_end, addr_end;

  always_comb begin
    cur      = phase_decode(alg_q, ph);
    op       = cur.ops[opi];
    base     = cur.down ? ~k : k;
    mem_addr = op.cpl_addr ? ~base : base;
    op_data  = ((alg_q == ALG_MARCH) ? '0 : cb_word(mem_addr)) ^ {DW{op.inv ^ cur.pol}};
    op_end   = (opi == cur.last_op);
    addr_end = (k == ADDR_TOP);
  end

  assign seq_last = running && op_end && addr_end && cur.last_ph;
  assign mem_we   = running && op.wr;
  assign mem_re   = running && !op.wr;
  assign alg_cur  = alg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      ph      <= '0;
      k       <= '0;
      opi     <= '0;
      alg_q   <= ALG_NONE;
    end else if (launch) begin
      running <= 1'b1;
      ph      <= '0;
      k       <= '0;
      opi     <= '0;
      alg_q   <= alg_in;
    end else if (halt) begin
      running <= 1'b0;
    end else if (running) begin
      if (!op_end) opi <= opi + 2'd1;
      else begin
        opi <= '0;
        if (!addr_end) k <= k + 1'b1;
        else begin
          k <= '0;
          if (cur.last_ph) running <= 1'b0;
          else ph <= ph + 3'd1;
        end
      end
    end
  end

  // R9: a stop request ends issuing at the next edge
  p_halt_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running && halt && !launch |=> !running);

endmodule

// File: rtl/ram_bist_cmp.sv
module ram_bist_cmp #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rd_issue,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_exp,
  input  logic [1:0]    alg,
  input  logic [DW-1:0] mem_rdata,
  output logic          cmp_fire,
  output logic          mismatch,
  output logic          fail_seen,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_act,
  output logic [1:0]    fail_alg
);

  logic          pend;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) pend <= 1'b0;
    else pend <= rd_issue;
    addr_q <= rd_addr;
    exp_q  <= rd_exp;
  end

  assign cmp_fire = pend;
  assign mismatch = pend && (mem_rdata != exp_q);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      fail_seen <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_act  <= '0;
      fail_alg  <= '0;
    end else if (mismatch && !fail_seen) begin
      fail_seen <= 1'b1;
      fail_addr <= addr_q;
      fail_exp  <= exp_q;
      fail_act  <= mem_rdata;
      fail_alg  <= alg;
    end
  end

  // R8: captured failure is frozen until the next clear
  p_fail_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_seen && !clear |=> $stable({fail_addr, fail_exp, fail_act, fail_alg}));

endmodule

// File: rtl/ram_bist.sv
module ram_bist
  import ram_bist_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int COL_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    algo_sel,
  input  logic          stop_on_fail,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_act,
  output logic [1:0]    fail_algo
);

  localparam int COL_CHK = (COL_W < AW) ? COL_W : 0;

  logic running, seq_last, tail, start_ok, halt;
  logic cmp_fire, mismatch, fail_seen;
  alg_e alg_cur;

  assign busy     = running || tail;
  assign start_ok = start && !busy && (algo_sel != ALG_NONE);
  assign halt     = mismatch && stop_on_fail && busy;
  assign pass     = done && !fail_seen;

  ram_bist_seq #(.AW(AW), .DW(DW), .COL_W(COL_CHK)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(start_ok), .halt(halt),
    .alg_in(alg_e'(algo_sel)), .alg_cur(alg_cur), .running(running),
    .seq_last(seq_last), .mem_addr(mem_addr), .op_data(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re)
  );

  ram_bist_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .rd_issue(mem_re),
    .rd_addr(mem_addr), .rd_exp(mem_wdata), .alg(alg_cur),
    .mem_rdata(mem_rdata), .cmp_fire(cmp_fire), .mismatch(mismatch),
    .fail_seen(fail_seen), .fail_addr(fail_addr), .fail_exp(fail_exp),
    .fail_act(fail_act), .fail_alg(fail_algo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || start_ok) begin
      tail <= 1'b0;
      done <= 1'b0;
    end else if (halt) begin
      tail <= 1'b0;
      done <= 1'b1;
    end else begin
      tail <= seq_last;
      if (tail) done <= 1'b1;
    end
  end

  // R7: every read strobe is followed by a compare cycle
  p_read_then_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> cmp_fire);
  // R10: a finished run is never busy
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2: invalid selection never launches a run
  p_bad_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && algo_sel == 2'd3 && !busy |=> !busy);

endmodule

// File: tb/sim_ram_bist.sv
module sim_ram_bist;
  localparam int CLK_NS = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int COLW = 2;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop_on_fail = 1'b0;
  logic [1:0] algo_sel = 2'd0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, fail_exp, fail_act;
  logic mem_we, mem_re, busy, done, pass;
  logic [1:0] fail_algo;

  int n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  ram_bist #(.AW(AW), .DW(DW), .COL_W(COLW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .algo_sel(algo_sel),
    .stop_on_fail(stop_on_fail), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .pass(pass), .fail_addr(fail_addr), .fail_exp(fail_exp),
    .fail_act(fail_act), .fail_algo(fail_algo)
  );

  // RAM model: one cycle of read latency, optional read fault at one address
  logic [DW-1:0] ram [NW];
  logic flt_en = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [DW-1:0] flt_and = '1, flt_or = '0;
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= (flt_en && mem_addr == flt_addr)
                             ? ((ram[mem_addr] & flt_and) | flt_or) : ram[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard of expected bus operations
  typedef struct packed { logic we; logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t q[$];
  item_t mon_e;
  bit mon_on = 0;
  string cur_req = "R3";

  function automatic logic [DW-1:0] tb_cb(input int a);
    return ((((a >> 0) & 1) ^ ((a >> COLW) & 1)) != 0) ? 8'h55 : 8'hAA;
  endfunction

  task automatic push(input bit we, input int a, input logic [DW-1:0] d);
    item_t it;
    it.we = we; it.a = AW'(a); it.d = d;
    q.push_back(it);
  endtask

  task automatic drive_march();
    for (int p = 0; p < 2; p++) begin
      logic [DW-1:0] b = (p == 1) ? 8'hFF : 8'h00;
      for (int a = 0; a < NW; a++) push(1, a, b);
      for (int a = 0; a < NW; a++) begin push(0, a, 0); push(1, a, ~b); push(0, a, 0); end
      for (int a = NW - 1; a >= 0; a--) begin push(0, a, 0); push(1, a, b); push(0, a, 0); end
    end
  endtask

  task automatic drive_acomp();
    for (int p = 0; p < 2; p++) begin
      logic [DW-1:0] m = (p == 1) ? 8'hFF : 8'h00;
      for (int a = 0; a < NW; a++) push(1, a, tb_cb(a) ^ m);
      for (int kk = 0; kk < NW; kk++) begin push(0, kk, 0); push(0, (NW - 1) - kk, 0); end
    end
  endtask

  task automatic drive_chkr();
    for (int p = 0; p < 2; p++) begin
      logic [DW-1:0] m = (p == 1) ? 8'hFF : 8'h00;
      for (int a = 0; a < NW; a++) push(1, a, tb_cb(a) ^ m);
      for (int a = 0; a < NW; a++) push(0, a, 0);
    end
  endtask

  // Monitor: compares each bus operation with the scoreboard head
  initial forever begin
    @(negedge clk);
    if (mon_on && (mem_we || mem_re)) begin
      if (q.size() == 0) chk(0, cur_req, "unexpected op at addr", 32'(mem_addr), 0);
      else begin
        mon_e = q.pop_front();
        chk(mem_we == mon_e.we, cur_req, "op kind", 32'(mem_we), 32'(mon_e.we));
        chk(mem_addr == mon_e.a, cur_req, "address", 32'(mem_addr), 32'(mon_e.a));
        if (mon_e.we) chk(mem_wdata == mon_e.d, cur_req, "write data", 32'(mem_wdata), 32'(mon_e.d));
      end
    end
  end

  task automatic run(input logic [1:0] sel, input bit sof, input bit poke, output int nbusy);
    @(negedge clk);
    algo_sel = sel; stop_on_fail = sof; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R10", "done cleared by start", 32'(done), 0);
    nbusy = 0;
    while (busy && nbusy < 5000) begin
      nbusy++;
      if (poke && nbusy == 10) begin start = 1'b1; algo_sel = 2'd2; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !mem_we && !mem_re, "R1", "reset outputs",
        {27'd0, busy, done, pass, mem_we, mem_re}, 0);
    rst_n = 1'b1;

    // R2: invalid selection ignored
    @(negedge clk); algo_sel = 2'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!busy && !mem_we && !mem_re, "R2", "invalid select idle", {30'd0, busy, mem_we | mem_re}, 0);
    @(negedge clk);
    chk(!busy && !done, "R2", "invalid select no run", {30'd0, busy, done}, 0);

    // R3, R4, R7: clean march
    cur_req = "R3"; drive_march(); mon_on = 1;
    run(2'd0, 0, 0, n);
    chk(n == 225, "R10", "march busy cycles", n, 225);
    chk(q.size() == 0, "R4", "march ops left", q.size(), 0);
    chk(done && pass, "R7", "clean march passes", {30'd0, done, pass}, 3);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R10", "done held", 32'(done), 1);

    // R5 plus R2: start while busy ignored
    cur_req = "R5"; drive_acomp();
    run(2'd1, 0, 1, n);
    chk(n == 97, "R2", "acomp length with mid-run start", n, 97);
    chk(q.size() == 0, "R5", "acomp ops left", q.size(), 0);
    chk(pass == 1'b1, "R5", "clean acomp passes", 32'(pass), 1);

    // R6 clean
    cur_req = "R6"; drive_chkr();
    run(2'd2, 0, 0, n);
    chk(n == 65, "R10", "checker busy cycles", n, 65);
    chk(q.size() == 0, "R6", "checker ops left", q.size(), 0);
    chk(pass == 1'b1, "R6", "clean checker passes", 32'(pass), 1);

    // R8: march, bit 3 stuck low at address 5, run to end
    flt_en = 1'b1; flt_addr = 4'd5; flt_and = 8'hF7; flt_or = 8'h00;
    cur_req = "R3"; drive_march();
    run(2'd0, 0, 0, n);
    chk(n == 225, "R8", "faulty march full length", n, 225);
    chk(done && !pass, "R8", "fail reported", {30'd0, done, pass}, 2);
    chk(fail_addr == 4'd5, "R8", "first fail addr", 32'(fail_addr), 5);
    chk(fail_exp == 8'hFF, "R8", "first fail expected", 32'(fail_exp), 32'hFF);
    chk(fail_act == 8'hF7, "R8", "first fail actual", 32'(fail_act), 32'hF7);
    chk(fail_algo == 2'd0, "R8", "first fail algorithm", 32'(fail_algo), 0);

    // R9: same fault, stop on fail; failing read is op 34
    mon_on = 0;
    run(2'd0, 1, 0, n);
    chk(n == 35, "R9", "stop cycle", n, 35);
    chk(done && !pass && fail_addr == 4'd5, "R9", "stopped with fail",
        {27'd0, done, pass, 3'd0}, {27'd0, 1'b1, 1'b0, 3'd0});
    q.delete();

    // R5 fault: bit 0 stuck low at address 9 (checkerboard 0x55)
    flt_addr = 4'd9; flt_and = 8'hFE; flt_or = 8'h00;
    cur_req = "R5"; drive_acomp(); mon_on = 1;
    run(2'd1, 0, 0, n);
    chk(n == 97, "R5", "faulty acomp length", n, 97);
    chk(fail_addr == 4'd9 && fail_algo == 2'd1, "R5", "acomp fail addr",
        32'(fail_addr), 9);
    chk(fail_exp == 8'h55 && fail_act == 8'h54, "R5", "acomp fail data",
        {16'd0, fail_exp, fail_act}, 32'h5554);

    // R6 fault: bit 7 stuck high at address 2, seen only by inverted pass
    flt_addr = 4'd2; flt_and = 8'hFF; flt_or = 8'h80;
    cur_req = "R6"; drive_chkr();
    run(2'd2, 0, 0, n);
    chk(fail_addr == 4'd2 && fail_algo == 2'd2, "R6", "checker fail addr",
        32'(fail_addr), 2);
    chk(fail_exp == 8'h55 && fail_act == 8'hD5, "R6", "inverted pass catches",
        {16'd0, fail_exp, fail_act}, 32'h55D5);

    // R8: new start clears the capture
    flt_en = 1'b0;
    cur_req = "R6"; drive_chkr();
    run(2'd2, 0, 0, n);
    chk(pass == 1'b1 && fail_addr == '0, "R8", "capture cleared", 32'(fail_addr), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule